// File: doc/BRIEF.md
# ADC Sample Buffer with Sticky Status and Interrupt

The block sits between an analog converter and a byte-wide host bus. Converted 16-bit samples are written into a first-in first-out store of parameterised depth. The host drains them through a single byte port. Each sample takes two reads of that port: the low byte comes first and the high byte second. The store moves on to the next sample only after the high byte has been read.

Alongside the store, the block keeps a set of sticky flags:
- FIFO overflow, when a sample is dropped.
- Conversion overrun, when a new conversion is started while one is still busy.
- Timer event, DMA terminal-count event, counter terminal-count event and external trigger event, each latched from an input pulse.

The host sees these flags and two live fill indications (data present, below half full) in two read-only status bytes. Writes to dedicated offsets clear the flags. Two enable bytes select which conditions drive a single level interrupt output.

The host decodes the bus down to a 5-bit offset. Reads have no latency: `bus_rdata` shows the addressed byte in the same cycle `bus_rd` is high. The side effect of a read (byte pointer step, sample pop) happens at the clock edge that ends that cycle.

Top module: `adc_sample_buffer`

## Requirements
- R1: After synchronous reset:
  - status byte 1 (read offset 0x00) is 0x00;
  - status byte 2 (read offset 0x1d) is 0x04;
  - both enable bytes are zero;
  - `irq` is low.
- R2: Offset 0x0a reads the oldest stored sample, low byte first and high byte second. Only the high-byte read removes the sample, so samples come out in the order they were written. Writing new samples between the two byte reads does not change this order.
- R3: A read of offset 0x0a while the store is empty returns 0x00. It does not move the byte pointer, so the next stored sample still starts with its low byte.
- R4: Status byte 1 bit 0 is high exactly while the store holds at least one sample.
- R5: Status byte 2 bit 2 is high while the stored count is below DEPTH/2, and low from DEPTH/2 upward.
- R6: When `sample_valid` arrives while the store holds DEPTH samples:
  - the sample is discarded;
  - status byte 1 bit 2 (overflow) sets and stays set;
  - the stored samples are untouched.
- R7: When `conv_start` arrives while `conv_busy` is high, status byte 1 bit 1 (overrun) sets and stays set. When `conv_start` arrives with `conv_busy` low, the bit is left alone.
- R8: Each input pulse sets a sticky flag:

  | Input pulse | Register | Bit |
  |---|---|---|
  | `timer_evt` | status byte 1 | 3 |
  | `dma_tc_evt` | status byte 1 | 4 |
  | `ext_trig_evt` | status byte 1 | 6 |
  | `count_tc_evt` | status byte 2 | 1 |

  Bits 5 and 7 of status byte 1 and bits 0, 3 to 7 of status byte 2 read 0.
- R9: Writes to three offsets act as clears; the written data is ignored.

  | Write offset | Effect |
  |---|---|
  | 0x08 | Empties the store, resets the byte pointer to the low byte, and clears overrun, overflow, external trigger and counter terminal-count flags |
  | 0x0c | Clears the timer flag |
  | 0x0a | Clears the DMA terminal-count flag |

  An event pulse in the same cycle as its clear leaves the flag set.
- R10: Enable byte A (write offset 0x02) has four enable bits:

  | Bit | Condition |
  |---|---|
  | 2 | DMA terminal count |
  | 3 | timer |
  | 4 | error (overrun or overflow) |
  | 5 | store not empty |

  Enable byte B (write offset 0x0e) has two enable bits:

  | Bit | Condition |
  |---|---|
  | 5 | store at or above half full |
  | 6 | counter terminal count |

- R11: `irq` is high exactly while at least one enabled condition is true. It stays high until that condition is cleared or its enable is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Push strobe for a converted sample |
| sample_data | input | 16 | Converted sample value |
| conv_start | input | 1 | Conversion start strobe |
| conv_busy | input | 1 | Converter busy with a conversion |
| timer_evt | input | 1 | Timer event pulse |
| dma_tc_evt | input | 1 | DMA terminal-count pulse |
| count_tc_evt | input | 1 | Hardware counter terminal-count pulse |
| ext_trig_evt | input | 1 | External trigger pulse |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data for the addressed offset |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check these properties on every cycle:
- the stored count stays within DEPTH;
- a clear always leaves the store empty;
- a high-byte read removes exactly one sample;
- an empty-port read leaves the byte pointer alone;
- a dropped sample always raises the overflow flag;
- `irq` stays low while both enable bytes are zero.

Other properties only show up in the bench scenarios:
- the byte order and first-in first-out order of returned data;
- the half-full boundary at DEPTH/2;
- which clear offset affects which flag;
- priority of an event over its same-cycle clear;
- the pairing of each enable bit with its condition.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

    // Read offsets
    localparam logic [4:0] OFS_STATUS1   = 5'h00;
    localparam logic [4:0] OFS_FIFO_PORT = 5'h0a;
    localparam logic [4:0] OFS_STATUS2   = 5'h1d;

    // Write offsets
    localparam logic [4:0] OFS_EN_A      = 5'h02;
    localparam logic [4:0] OFS_CLR_ADC   = 5'h08;
    localparam logic [4:0] OFS_CLR_DMATC = 5'h0a;
    localparam logic [4:0] OFS_CLR_TIMER = 5'h0c;
    localparam logic [4:0] OFS_EN_B      = 5'h0e;

    // Sticky event flags
    typedef struct packed {
        logic ext_trig;
        logic count_tc;
        logic dma_tc;
        logic timer;
        logic overflow;
        logic overrun;
    } evt_flags_t;

    // Interrupt enables gathered from both enable bytes
    typedef struct packed {
        logic count_tc;
        logic half_full;
        logic not_empty;
        logic error;
        logic timer;
        logic dma_tc;
    } irq_en_t;

    function automatic logic [7:0] pack_status1(evt_flags_t f, logic avail);
        return {1'b0, f.ext_trig, 1'b0, f.dma_tc, f.timer, f.overflow, f.overrun, avail};
    endfunction

    function automatic logic [7:0] pack_status2(evt_flags_t f, logic below_half);
        return {5'b0, below_half, f.count_tc, 1'b0};
    endfunction

endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
    parameter int DEPTH = 512,   // power of two
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             dropped
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, accept, take;

    assign full    = (count == CW'(DEPTH));
    assign accept  = push && !full && !flush;
    assign take    = pop && (count != '0) && !flush;
    assign dropped = push && full && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (take)   rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(accept) - CW'(take);
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/adc_event_flags.sv
module adc_event_flags
    import adc_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_adc,
    input  logic       clr_timer,
    input  logic       clr_dmatc,
    input  logic       overrun_set,
    input  logic       overflow_set,
    input  logic       timer_set,
    input  logic       dmatc_set,
    input  logic       count_tc_set,
    input  logic       ext_trig_set,
    output evt_flags_t flags
);
    // A set in the same cycle as its clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.overrun  <= overrun_set  | (flags.overrun  & ~clr_adc);
            flags.overflow <= overflow_set | (flags.overflow & ~clr_adc);
            flags.ext_trig <= ext_trig_set | (flags.ext_trig & ~clr_adc);
            flags.count_tc <= count_tc_set | (flags.count_tc & ~clr_adc);
            flags.timer    <= timer_set    | (flags.timer    & ~clr_timer);
            flags.dma_tc   <= dmatc_set    | (flags.dma_tc   & ~clr_dmatc);
        end
    end

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow_set |=> flags.overflow);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flags.overrun && !clr_adc) |=> flags.overrun);

endmodule

// File: rtl/adc_irq_ctl.sv
module adc_irq_ctl
    import adc_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_a,
    input  logic       wr_en_b,
    input  logic [7:0] wdata,
    input  evt_flags_t flags,
    input  logic       not_empty,
    input  logic       at_half,
    output logic       irq
);
    irq_en_t en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else begin
            if (wr_en_a) begin
                en.dma_tc    <= wdata[2];
                en.timer     <= wdata[3];
                en.error     <= wdata[4];
                en.not_empty <= wdata[5];
            end
            if (wr_en_b) begin
                en.half_full <= wdata[5];
                en.count_tc  <= wdata[6];
            end
        end
    end

    assign irq = (en.dma_tc    & flags.dma_tc)
               | (en.timer     & flags.timer)
               | (en.error     & (flags.overrun | flags.overflow))
               | (en.not_empty & not_empty)
               | (en.half_full & at_half)
               | (en.count_tc  & flags.count_tc);

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
    import adc_buf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_valid,
    input  logic [15:0] sample_data,
    input  logic        conv_start,
    input  logic        conv_busy,
    input  logic        timer_evt,
    input  logic        dma_tc_evt,
    input  logic        count_tc_evt,
    input  logic        ext_trig_evt,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        irq
);
    logic [15:0]  head;
    logic [CW-1:0] count;
    logic         dropped, non_empty, below_half, byte_hi;
    logic         rd_port, pop, clr_adc;
    evt_flags_t   flags;

    assign clr_adc    = bus_wr && (bus_addr == OFS_CLR_ADC);
    assign rd_port    = bus_rd && (bus_addr == OFS_FIFO_PORT);
    assign non_empty  = (count != '0);
    assign below_half = (count < CW'(DEPTH / 2));
    assign pop        = rd_port && non_empty && byte_hi;

    adc_fifo_store #(.DEPTH(DEPTH), .WIDTH(16)) u_store (
        .clk(clk), .rst(rst), .flush(clr_adc),
        .push(sample_valid), .push_data(sample_data),
        .pop(pop), .head(head), .count(count), .dropped(dropped)
    );

    adc_event_flags u_flags (
        .clk(clk), .rst(rst),
        .clr_adc(clr_adc),
        .clr_timer(bus_wr && (bus_addr == OFS_CLR_TIMER)),
        .clr_dmatc(bus_wr && (bus_addr == OFS_CLR_DMATC)),
        .overrun_set(conv_start && conv_busy),
        .overflow_set(dropped),
        .timer_set(timer_evt), .dmatc_set(dma_tc_evt),
        .count_tc_set(count_tc_evt), .ext_trig_set(ext_trig_evt),
        .flags(flags)
    );

    adc_irq_ctl u_irq (
        .clk(clk), .rst(rst),
        .wr_en_a(bus_wr && (bus_addr == OFS_EN_A)),
        .wr_en_b(bus_wr && (bus_addr == OFS_EN_B)),
        .wdata(bus_wdata), .flags(flags),
        .not_empty(non_empty), .at_half(!below_half),
        .irq(irq)
    );

    // Byte pointer: toggles on each port read that finds data.
    always_ff @(posedge clk) begin
        if (rst || clr_adc)               byte_hi <= 1'b0;
        else if (rd_port && non_empty)    byte_hi <= ~byte_hi;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STATUS1:   bus_rdata = pack_status1(flags, non_empty);
            OFS_STATUS2:   bus_rdata = pack_status2(flags, below_half);
            OFS_FIFO_PORT: bus_rdata = !non_empty ? 8'h00 :
                                       (byte_hi ? head[15:8] : head[7:0]);
            default:       bus_rdata = 8'h00;
        endcase
    end

    assert_pop_after_high_R2: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr_adc && !sample_valid) |=> (count == $past(count) - 1'b1));

    assert_empty_read_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_port && !non_empty && !clr_adc) |=> $stable(byte_hi));

endmodule

// File: tb/test_adc_sample_buffer.sv
module test_adc_sample_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic        sample_valid = 0;
    logic [15:0] sample_data = '0;
    logic        conv_start = 0, conv_busy = 0;
    logic        timer_evt = 0, dma_tc_evt = 0, count_tc_evt = 0, ext_trig_evt = 0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_buffer #(.DEPTH(DEPTH)) i_adc_sample_buffer (
        .clk(clk), .rst(rst),
        .sample_valid(sample_valid), .sample_data(sample_data),
        .conv_start(conv_start), .conv_busy(conv_busy),
        .timer_evt(timer_evt), .dma_tc_evt(dma_tc_evt),
        .count_tc_evt(count_tc_evt), .ext_trig_evt(ext_trig_evt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, int got, int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic push(logic [15:0] d);
        @(negedge clk);
        sample_valid = 1; sample_data = d;
        @(posedge clk); #1;
        sample_valid = 0;
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: dma_tc_evt = 1;
            1: timer_evt = 1;
            2: begin conv_start = 1; conv_busy = 1; end
            3: ext_trig_evt = 1;
            default: count_tc_evt = 1;
        endcase
        @(posedge clk); #1;
        dma_tc_evt = 0; timer_evt = 0; conv_start = 0; conv_busy = 0;
        ext_trig_evt = 0; count_tc_evt = 0;
    endtask

    function automatic logic [15:0] pat(int k);
        return 16'h0F00 ^ 16'(k * 16'h1357);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] lo;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd(5'h00, v); check("R1 status1", v, 8'h00);
        rd(5'h1d, v); check("R1 status2", v, 8'h04);
        @(negedge clk); check("R1 irq", irq, 0);

        // R2 / R4 single sample
        push(16'h1234);
        rd(5'h00, v); check("R4 avail set", v, 8'h01);
        rd(5'h0a, v); check("R2 low byte", v, 8'h34);
        rd(5'h0a, v); check("R2 high byte", v, 8'h12);
        rd(5'h00, v); check("R4 avail clear", v, 8'h00);

        // R5 fill sweep, R6 overflow
        for (int k = 0; k < DEPTH; k++) begin
            push(pat(k));
            rd(5'h1d, v);
            check("R5 below half", v[2], (k + 1 < DEPTH / 2) ? 1 : 0);
        end
        push(16'hDEAD);
        rd(5'h00, v); check("R6 overflow flag", v, 8'h05);
        for (int k = 0; k < DEPTH; k++) begin
            rd(5'h0a, v); check("R2 order low", v, int'(pat(k) & 16'hFF));
            rd(5'h0a, v); check("R2 order high", v, int'(pat(k) >> 8));
        end
        rd(5'h00, v); check("R6 still sticky", v, 8'h04);

        // R3 empty reads
        rd(5'h0a, v); check("R3 empty read", v, 8'h00);
        rd(5'h0a, v); check("R3 empty read again", v, 8'h00);
        push(16'hBEEF);
        rd(5'h0a, v); check("R3 pointer held low", v, 8'hEF);
        rd(5'h0a, v); check("R3 pointer then high", v, 8'hBE);

        // R2 writes between byte reads
        push(16'hA1B2);
        rd(5'h0a, v); check("R2 interleave lo", v, 8'hB2);
        push(16'hC3D4);
        rd(5'h0a, v); check("R2 interleave hi", v, 8'hA1);
        rd(5'h0a, v); check("R2 next lo", v, 8'hD4);
        rd(5'h0a, v); check("R2 next hi", v, 8'hC3);

        // R9 clear resets pointer and overflow
        push(16'h5566);
        rd(5'h0a, lo); check("R9 pre-clear lo", lo, 8'h66);
        wr(5'h08, 8'h00);
        rd(5'h00, v); check("R9 adc clear status1", v, 8'h00);
        rd(5'h0a, v); check("R9 read after clear", v, 8'h00);
        push(16'h7788);
        rd(5'h0a, v); check("R9 pointer reset", v, 8'h88);
        wr(5'h08, 8'hFF);

        // R7 overrun
        @(negedge clk); conv_start = 1; conv_busy = 0;
        @(posedge clk); #1 conv_start = 0;
        rd(5'h00, v); check("R7 idle start ignored", v, 8'h00);
        pulse(2);
        rd(5'h00, v); check("R7 overrun set", v, 8'h02);

        // R8 events
        pulse(0); pulse(1); pulse(3); pulse(4);
        rd(5'h00, v); check("R8 status1 events", v, 8'h5A);
        rd(5'h1d, v); check("R8 status2 count tc", v, 8'h06);
        wr(5'h0c, 8'h00);
        rd(5'h00, v); check("R9 timer clear", v, 8'h52);
        wr(5'h0a, 8'h00);
        rd(5'h00, v); check("R9 dma clear", v, 8'h42);
        wr(5'h08, 8'h00);
        rd(5'h00, v); check("R9 adc clear flags", v, 8'h00);
        rd(5'h1d, v); check("R9 adc clear status2", v, 8'h04);

        // R9 event beats same-cycle clear
        @(negedge clk);
        timer_evt = 1; bus_addr = 5'h0c; bus_wr = 1;
        @(posedge clk); #1 timer_evt = 0; bus_wr = 0;
        rd(5'h00, v); check("R9 set wins over clear", v, 8'h08);
        wr(5'h0c, 8'h00);

        // R10 / R11 each enable against its condition
        for (int c = 0; c < 6; c++) begin
            logic [4:0] en_ofs;
            logic [7:0] en_val;
            logic [4:0] clr_ofs;
            case (c)
                0: begin en_ofs = 5'h02; en_val = 8'h04; clr_ofs = 5'h0a; pulse(0); end
                1: begin en_ofs = 5'h02; en_val = 8'h08; clr_ofs = 5'h0c; pulse(1); end
                2: begin en_ofs = 5'h02; en_val = 8'h10; clr_ofs = 5'h08; pulse(2); end
                3: begin en_ofs = 5'h02; en_val = 8'h20; clr_ofs = 5'h08; push(16'h0001); end
                4: begin en_ofs = 5'h0e; en_val = 8'h20; clr_ofs = 5'h08;
                         for (int j = 0; j < DEPTH / 2; j++) push(16'(j)); end
                default: begin en_ofs = 5'h0e; en_val = 8'h40; clr_ofs = 5'h08; pulse(4); end
            endcase
            @(negedge clk); check("R11 disabled irq low", irq, 0);
            // other enables set, this one clear: still low
            wr(en_ofs, ~en_val & ((en_ofs == 5'h02) ? 8'h3C : 8'h60));
            @(negedge clk); check("R10 other enables irq low", irq, (c == 3 && en_ofs == 5'h02) ? 0 : 0);
            wr(en_ofs, en_val);
            @(negedge clk); check("R10 enable raises irq", irq, 1);
            repeat (2) @(negedge clk);
            check("R11 irq holds", irq, 1);
            wr(en_ofs, 8'h00);
            @(negedge clk); check("R11 disable drops irq", irq, 0);
            wr(en_ofs, en_val);
            wr(clr_ofs, 8'h00);
            @(negedge clk); check("R11 clear drops irq", irq, 0);
            wr(en_ofs, 8'h00);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule